// File: doc/BRIEF.md
# Multiplexed Line-Interface Control Port Scanner

This block owns a 12-pin general-purpose pin bus that four external line-interface circuits share, and it selects each circuit with its own active-low chip select. In scan mode it visits the selects in a fixed round-robin order. While a select is low, the pins marked as outputs carry that channel's data register, and the pins marked as inputs are captured back into the same register at the end of the window. In static mode the bus is not multiplexed: one data register (channel 0) drives and captures the pins continuously, and the select pins are released.

A host reads and writes a small byte-wide register file. It holds one configuration byte, one direction mask that all channels share, and a 12-bit data register per channel, each split into a low byte and a high nibble. A timebase strobe paces the scan. One slot lasts `SLOT_TICKS` strobes, and a full frame of four slots should last 31.25 µs, so the strobe period is 31.25 µs / (4·`SLOT_TICKS`). The first strobe period of every slot is an idle gap with no select low. A configuration bit returns the whole block to its reset state.

Top module: `lic_scan_port`

## Requirements
- R1: After reset, the configuration byte reads 3Fh, and the direction and all data registers read 0. `io_oe` and `cs_oe` are all zero.
- R2: The register map is: 0 = configuration, 1 = direction bits 7..0, 2 = direction bits 11..8, then 3+2n and 4+2n = data channel n bits 7..0 and 11..8. High-nibble registers read bits 7..4 as 0 and ignore writes to them. Configuration bit 7 reads 0. Addresses 0Bh..0Fh read 0.
- R3: When configuration bit 4 is 0 (scan mode), `cs_oe` is all ones. The scan starts with an idle strobe period, then holds select n low (`cs_n_o` = ~(1<<n)) for `SLOT_TICKS`-1 strobe periods. An idle period with all selects high follows, and then the next channel in the order 0,1,2,3,0… is selected. No more than one select is ever low, and two selects are never low in adjacent cycles.
- R4: In scan mode, while select n is low, `io_oe` equals the direction mask and `io_out` equals data register n. In the idle gap `io_oe` is 0.
- R5: In scan mode, on the last strobe of select n's window, the bits of data register n that have direction 0 take the value of `io_in` after a two-flop synchroniser. Bits with direction 1 keep their value.
- R6: A host write to either byte of data register n in the capture cycle of channel n takes precedence. The written byte takes the host data, and the other byte is left unchanged.
- R7: When configuration bit 4 is 1 (static mode), `cs_oe` is 0, `io_oe` equals the direction mask and `io_out` equals data register 0. The input-direction bits of data register 0 follow the synchronised `io_in` every clock. The other data registers are untouched.
- R8: Writing the configuration byte with bit 7 set restores every register to its reset value in the next cycle, which makes all pins and selects inputs.
- R9: The scan advances only on clocks where `tick` is 1. With `tick` held at 0, `cs_n_o` holds and no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timebase strobe that advances the scan |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational from address) |
| io_in | input | 12 | Pin bus input values |
| io_out | output | 12 | Pin bus output values |
| io_oe | output | 12 | Pin bus output enables, 1 = drive |
| cs_n_o | output | 4 | Active-low chip select values |
| cs_oe | output | 4 | Chip select output enables |

## Verification
The bench writes to a data register in the exact cycle that channel captures. A design that lets the capture win would show the synchronised input pins in that register instead of the host byte, or would disturb the other byte. It counts the cycles of the first scanned frame to prove the idle gap and the select order: a design that drops the gap or starts at the wrong channel shows the wrong `cs_n_o` in a named cycle. It also checks that scan captures touch only the input-direction bits, and that static mode captures only into channel 0. Writing the reset bit must return every register to its reset value, and holding `tick` low must freeze the selects.

// File: rtl/lic_scan_pkg.sv
package lic_scan_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned A_CONF   = 0;
  localparam int unsigned A_DIRL   = 1;
  localparam int unsigned A_DIRH   = 2;
  localparam int unsigned A_DATA0  = 3;
  localparam int unsigned STA_BIT  = 4;
  localparam int unsigned SRST_BIT = 7;
  localparam logic [7:0]  CONF_RST = 8'h3F;
endpackage

// File: rtl/lic_scan_sync.sv
module lic_scan_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lic_scan_timer.sv
module lic_scan_timer #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned SLOT_TICKS = 4,
  localparam int unsigned CH_W      = $clog2(NCH),
  localparam int unsigned PH_W      = $clog2(SLOT_TICKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            scan_en,
  output logic [CH_W-1:0] ch_o,
  output logic            active_o,
  output logic            capture_o
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            last_ph, last_ch;

  assign last_ph = (ph_q == PH_W'(SLOT_TICKS - 1));
  assign last_ch = (ch_q == CH_W'(NCH - 1));

  always_comb begin
    ph_d = ph_q;
    ch_d = ch_q;
    if (!scan_en) begin
      ph_d = '0;
      ch_d = '0;
    end else if (tick) begin
      if (last_ph) begin
        ph_d = '0;
        ch_d = last_ch ? '0 : ch_q + CH_W'(1);
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      ch_q <= '0;
    end else begin
      ph_q <= ph_d;
      ch_q <= ch_d;
    end
  end

  assign ch_o      = ch_q;
  assign active_o  = scan_en && (ph_q != '0);
  assign capture_o = active_o && tick && last_ph;
endmodule

// File: rtl/lic_scan_regs.sv
module lic_scan_regs
  import lic_scan_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned PIN_W = 12,
  localparam int unsigned CH_W = $clog2(NCH),
  localparam int unsigned HI_W = PIN_W - 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  input  logic [PIN_W-1:0]           io_sync,
  input  logic                       capture,
  input  logic [CH_W-1:0]            cap_ch,
  output logic                       sta_o,
  output logic [PIN_W-1:0]           dir_o,
  output logic [NCH-1:0][PIN_W-1:0]  data_o
);
  logic [6:0]                      conf_q, conf_d;
  logic [PIN_W-1:0]                dir_q, dir_d;
  logic [NCH-1:0][PIN_W-1:0]       data_q, data_d;
  logic                            soft_rst;
  logic                            sta;

  assign sta      = conf_q[STA_BIT];
  assign soft_rst = we && (addr == ADDR_W'(A_CONF)) && wdata[SRST_BIT];

  always_comb begin
    logic hit_lo, hit_hi, take;
    conf_d = conf_q;
    dir_d  = dir_q;
    data_d = data_q;
    if (we && addr == ADDR_W'(A_CONF)) conf_d = wdata[6:0];
    if (we && addr == ADDR_W'(A_DIRL)) dir_d[7:0] = wdata;
    if (we && addr == ADDR_W'(A_DIRH)) dir_d[PIN_W-1:8] = wdata[HI_W-1:0];
    for (int n = 0; n < NCH; n++) begin
      hit_lo = we && (addr == ADDR_W'(A_DATA0 + 2*n));
      hit_hi = we && (addr == ADDR_W'(A_DATA0 + 2*n + 1));
      take   = sta ? (n == 0) : (capture && cap_ch == CH_W'(n));
      if (take && !hit_lo && !hit_hi)
        data_d[n] = (data_q[n] & dir_q) | (io_sync & ~dir_q);
      if (hit_lo) data_d[n][7:0] = wdata;
      if (hit_hi) data_d[n][PIN_W-1:8] = wdata[HI_W-1:0];
    end
    if (soft_rst) begin
      conf_d = CONF_RST[6:0];
      dir_d  = '0;
      data_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_q <= CONF_RST[6:0];
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      conf_q <= conf_d;
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_W'(A_CONF)) rdata = {1'b0, conf_q};
    if (addr == ADDR_W'(A_DIRL)) rdata = dir_q[7:0];
    if (addr == ADDR_W'(A_DIRH)) rdata = 8'(dir_q[PIN_W-1:8]);
    for (int n = 0; n < NCH; n++) begin
      if (addr == ADDR_W'(A_DATA0 + 2*n))     rdata = data_q[n][7:0];
      if (addr == ADDR_W'(A_DATA0 + 2*n + 1)) rdata = 8'(data_q[n][PIN_W-1:8]);
    end
  end

  assign sta_o  = sta;
  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/lic_scan_pinmux.sv
module lic_scan_pinmux #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned PIN_W = 12,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                      sta,
  input  logic                      active,
  input  logic [CH_W-1:0]           ch,
  input  logic [PIN_W-1:0]          dir,
  input  logic [NCH-1:0][PIN_W-1:0] data,
  output logic [PIN_W-1:0]          io_out,
  output logic [PIN_W-1:0]          io_oe,
  output logic [NCH-1:0]            cs_n_o,
  output logic [NCH-1:0]            cs_oe
);
  logic [NCH-1:0] sel;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign sel[g] = !sta && active && (ch == CH_W'(g));
  end

  always_comb begin
    cs_n_o = ~sel;
    cs_oe  = sta ? '0 : '1;
    io_out = '0;
    io_oe  = '0;
    if (sta) begin
      io_out = data[0];
      io_oe  = dir;
    end else if (active) begin
      io_out = data[ch];
      io_oe  = dir;
    end
  end
endmodule

// File: rtl/lic_scan_port.sv
module lic_scan_port
  import lic_scan_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned PIN_W      = 12,
  parameter int unsigned SLOT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [PIN_W-1:0]  io_in,
  output logic [PIN_W-1:0]  io_out,
  output logic [PIN_W-1:0]  io_oe,
  output logic [NCH-1:0]    cs_n_o,
  output logic [NCH-1:0]    cs_oe
);
  localparam int unsigned CH_W = $clog2(NCH);

  logic [1:0]                rs_q;
  logic                      rst_i_n;
  logic [PIN_W-1:0]          io_sync;
  logic                      sta, active, capture;
  logic [CH_W-1:0]           ch;
  logic [PIN_W-1:0]          dir;
  logic [NCH-1:0][PIN_W-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  lic_scan_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(io_in), .q(io_sync)
  );

  lic_scan_timer #(.NCH(NCH), .SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .scan_en(!sta),
    .ch_o(ch), .active_o(active), .capture_o(capture)
  );

  lic_scan_regs #(.NCH(NCH), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .io_sync(io_sync),
    .capture(capture), .cap_ch(ch), .sta_o(sta), .dir_o(dir), .data_o(data)
  );

  lic_scan_pinmux #(.NCH(NCH), .PIN_W(PIN_W)) u_mux (
    .sta(sta), .active(active), .ch(ch), .dir(dir), .data(data),
    .io_out(io_out), .io_oe(io_oe), .cs_n_o(cs_n_o), .cs_oe(cs_oe)
  );
endmodule

// File: rtl/lic_scan_chk.sv
module lic_scan_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned PIN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             reg_we,
  input logic [3:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic [PIN_W-1:0] io_oe,
  input logic [NCH-1:0]   cs_n_o,
  input logic [NCH-1:0]   cs_oe
);
  localparam logic [NCH-1:0] ALL1 = '1;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o)); // R3

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_oe == ALL1 && !(&cs_n_o)) |=> ((&cs_n_o) || $stable(cs_n_o))); // R3

  AST_CS_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_oe == '0) || (cs_oe == ALL1)); // R7

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_oe == ALL1 && (&cs_n_o)) |-> (io_oe == '0)); // R4

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && cs_oe == ALL1 && !(reg_we && reg_addr == 4'h0)) |=> $stable(cs_n_o)); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h0 && reg_wdata[7]) |=> (io_oe == '0 && cs_oe == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= 4'(3 + 2*NCH)) |-> (reg_rdata == 8'h00)); // R2
endmodule

bind lic_scan_port lic_scan_chk #(.NCH(NCH), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .io_oe(io_oe), .cs_n_o(cs_n_o), .cs_oe(cs_oe)
);

// File: tb/tb_lic_scan_port.sv
module tb_lic_scan_port;
  logic        clk, rst_n, tick, reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [11:0] io_in, io_out, io_oe;
  logic [3:0]  cs_n_o, cs_oe;
  int          n_chk = 0, n_fail = 0;
  bit          done  = 0;

  lic_scan_port dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .cs_n_o(cs_n_o), .cs_oe(cs_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, write data, expected read-back}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'h1, 8'hFF, 8'hFF}, {4'h2, 8'hFF, 8'h0F}, {4'h3, 8'h12, 8'h12},
    {4'h4, 8'hF3, 8'h03}, {4'h5, 8'h34, 8'h34}, {4'h6, 8'h05, 8'h05},
    {4'h7, 8'h56, 8'h56}, {4'h8, 8'h87, 8'h07}, {4'h9, 8'h78, 8'h78},
    {4'hA, 8'h19, 8'h09}, {4'hB, 8'hEE, 8'h00}, {4'hF, 8'h33, 8'h00},
    {4'h0, 8'h7F, 8'h7F}, {4'h0, 8'h5A, 8'h5A}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic waitn(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    logic [11:0] dirm, wv, ev;
    rst_n = 1'b0; tick = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; io_in = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(3);
    rd("R1 conf", 4'h0, 8'h3F);
    rd("R1 dir lo", 4'h1, 8'h00);
    rd("R1 data1 lo", 4'h5, 8'h00);
    chk("R1 io_oe", {4'h0, io_oe}, 16'h0);
    chk("R1 cs_oe", {12'h0, cs_oe}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd("R2 map", VEC[i][19:16], VEC[i][7:0]);
    end

    // static mode, all outputs
    chk("R7 static oe", {4'h0, io_oe}, 16'h0FFF);
    chk("R7 static out", {4'h0, io_out}, 16'h0312);
    chk("R7 static cs_oe", {12'h0, cs_oe}, 16'h0);
    wr(4'h1, 8'h0F); wr(4'h2, 8'h00); wr(4'h3, 8'h05); wr(4'h4, 8'h00);
    io_in = 12'hAB0;
    waitn(4);
    rd("R7 static capture lo", 4'h3, 8'hB5);
    rd("R7 static capture hi", 4'h4, 8'h0A);
    rd("R7 data1 untouched", 4'h5, 8'h34);
    chk("R7 static out bits", {4'h0, io_out & io_oe}, 16'h0005);

    wr(4'h0, 8'h80);
    rd("R8 conf", 4'h0, 8'h3F);
    rd("R8 dir hi", 4'h2, 8'h00);
    rd("R8 data3 lo", 4'h9, 8'h00);
    chk("R8 io_oe", {4'h0, io_oe}, 16'h0);
    chk("R8 cs_oe", {12'h0, cs_oe}, 16'h0);

    // scan mode
    dirm = 12'h0F0;
    io_in = 12'hC3C;
    wr(4'h1, 8'hF0); wr(4'h2, 8'h00);
    for (int n = 0; n < 4; n++) begin
      wr(4'(3 + 2*n), 8'(8'hA0 + 16*n));
      wr(4'(4 + 2*n), 8'h05);
    end
    waitn(3);
    wr(4'h0, 8'h00);
    chk("R3 first idle cs", {12'h0, cs_n_o}, 16'h000F);
    chk("R3 scan cs_oe", {12'h0, cs_oe}, 16'h000F);
    chk("R4 first idle oe", {4'h0, io_oe}, 16'h0);
    for (int n = 0; n < 4; n++) begin
      wv = {4'h5, 8'(8'hA0 + 16*n)};
      for (int p = 1; p < 4; p++) begin
        @(negedge clk);
        chk("R3 select", {12'h0, cs_n_o}, {12'h0, ~(4'b0001 << n)});
        chk("R4 drive oe", {4'h0, io_oe}, {4'h0, dirm});
        chk("R4 drive out", {4'h0, io_out & dirm}, {4'h0, wv & dirm});
      end
      @(negedge clk);
      chk("R3 gap", {12'h0, cs_n_o}, 16'h000F);
      chk("R4 gap oe", {4'h0, io_oe}, 16'h0);
    end
    for (int n = 0; n < 4; n++) begin
      wv = {4'h5, 8'(8'hA0 + 16*n)};
      ev = (wv & dirm) | (12'hC3C & ~dirm);
      rd("R5 capture lo", 4'(3 + 2*n), ev[7:0]);
      rd("R5 capture hi", 4'(4 + 2*n), {4'h0, ev[11:8]});
    end

    @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 hold", {12'h0, cs_n_o}, 16'h000E);
    end
    tick = 1'b1;

    // host write in the capture cycle of channel 1
    wr(4'h0, 8'h80);
    io_in = 12'hFFF;
    wr(4'h1, 8'h00); wr(4'h2, 8'h00);
    waitn(3);
    wr(4'h0, 8'h00);
    waitn(7);
    wr(4'h5, 8'h5A);
    rd("R6 write wins lo", 4'h5, 8'h5A);
    rd("R6 other byte kept", 4'h6, 8'h00);
    waitn(4);
    rd("R5 ch2 capture lo", 4'h7, 8'hFF);
    rd("R5 ch2 capture hi", 4'h8, 8'h0F);
    waitn(12);
    rd("R6 next frame capture", 4'h5, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule